// File: doc/BRIEF.md
# Control/Status Register with External Clock Detection

This block is the shared control and status register of a trigger-routing unit. Software writes it to choose one of four quarter-period phase offsets for an external reference clock, and to fire a software reset. That reset leaves the block as a one-cycle pulse, which the rest of the unit uses to disable its channels or counters. The same write also returns the phase to zero.

A read of the register returns a status byte with these fields:

- The synchronized PLL-unlock input.
- The current phase selection.
- Whether an external reference clock is present.
- A one-hot unit type, decoded from the two-bit slot address.
- A sticky flag showing that a software reset happened since the last read.

A window monitor runs on the internal clock and watches the synchronized external clock. It declares that clock present or lost at the end of each window. Its verdict drives the clock-select output, so the unit switches to the external clock automatically whenever one is present.

Top module: `csr_clkdet`

## Requirements
- R1: After the synchronous reset, the phase is 0, the sticky flag is 0, the reset pulse is low and the external clock is reported absent; with slot 0 the read value is 8'h02.
- R2: A write with bit 0 clear loads bits 6:5 into the phase selection (00=0, 01=90, 10=180, 11=270 degrees); the phase drives phase_sel and reads back in bits 6:5.
- R3: A write with bit 0 set drives sw_reset_pulse high for exactly the one cycle after the write, and forces the phase to 0 whatever bits 6:5 hold.
- R4: Read bits 3:1 give the unit type, one-hot. Slot 0 or 3 sets bit 1 (multiplexer unit), slot 1 sets bit 2 (low receiver) and slot 2 sets bit 3 (high receiver).
- R5: Read bit 0 is set by a software reset write.
- R6: A read clears bit 0 after returning it. When a read and a software reset write occur in the same cycle, the flag stays set.
- R7: Windows of 256 internal cycles are counted from reset release. When a window sees at least 4 rising edges of the synchronized external clock, read bit 4 and ext_clk_sel are set at the end of that window.
- R8: A window with no external edges clears bit 4 and ext_clk_sel. A window with 1 to 3 edges leaves them unchanged.
- R9: Read bit 7 reports pll_unlocked after a two-stage synchronizer.
- R10: Write bits 7 and 4:1 are ignored, and a write with bit 0 clear produces no reset pulse and leaves the sticky flag alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_addr | input | 2 | Slot address strap selecting the unit type |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe, clears the sticky flag |
| rd_data | output | 8 | Register read data |
| ext_clk | input | 1 | External reference clock, asynchronous |
| pll_unlocked | input | 1 | PLL unlock indication, asynchronous |
| phase_sel | output | 2 | Phase selection for the external clock shifter |
| ext_clk_sel | output | 1 | High selects the external clock |
| sw_reset_pulse | output | 1 | One-cycle software reset to the unit |

## Verification
On every cycle, the assertions check the following:

- A reset pulse only ever follows a reset write.
- The phase is zero and the sticky flag is set while that pulse is high.
- A read with no competing reset write clears the flag.
- The unit type stays one-hot.
- The clock-present verdict changes only at a window boundary, and it falls only after an empty window.

Some properties are only shown by the bench's scenarios. These are the full phase table through read-back, the ignored bits, and the read-versus-reset priority. The same holds for the detector outcomes: a dense toggle train is found, sparse edges keep the verdict, silence loses it, and three isolated edges never activate it.

// File: rtl/csr_pkg.sv
package csr_pkg;

    typedef enum logic [1:0] {
        PH_0   = 2'd0,
        PH_90  = 2'd1,
        PH_180 = 2'd2,
        PH_270 = 2'd3
    } phase_e;

    typedef struct packed {
        logic hi_rx;
        logic lo_rx;
        logic mux;
    } unit_t;

    typedef struct packed {
        logic   pll_unlock;
        phase_e phase;
        logic   ext_active;
        unit_t  unit;
        logic   rst_flag;
    } csr_view_t;

    localparam int CSR_W = $bits(csr_view_t);

    function automatic unit_t decode_slot(input logic [1:0] slot);
        unit_t u;
        u = '0;
        case (slot)
            2'd1:    u.lo_rx = 1'b1;
            2'd2:    u.hi_rx = 1'b1;
            default: u.mux   = 1'b1;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/csr_sync.sv
module csr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d_async;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/csr_clk_monitor.sv
module csr_clk_monitor #(
    parameter int WIN_LEN  = 256,
    parameter int EDGE_MIN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_lvl,
    output logic active
);
    localparam int WIN_W = $clog2(WIN_LEN);
    localparam int CNT_W = $clog2(EDGE_MIN + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(EDGE_MIN);

    logic             lvl_q;
    logic             rise;
    logic [WIN_W-1:0] win_cnt;
    logic             win_end;
    logic [CNT_W-1:0] edge_cnt;
    logic [CNT_W-1:0] cnt_next;

    assign rise     = ext_lvl & ~lvl_q;
    assign win_end  = (win_cnt == WIN_LAST);
    assign cnt_next = (rise && edge_cnt != CNT_SAT) ? edge_cnt + 1'b1 : edge_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q    <= 1'b0;
            win_cnt  <= '0;
            edge_cnt <= '0;
            active   <= 1'b0;
        end else begin
            lvl_q   <= ext_lvl;
            win_cnt <= win_end ? '0 : win_cnt + 1'b1;
            if (win_end) begin
                edge_cnt <= '0;
                if (cnt_next == CNT_SAT)
                    active <= 1'b1;
                else if (cnt_next == '0)
                    active <= 1'b0;
            end else begin
                edge_cnt <= cnt_next;
            end
        end
    end

    // R7: presence is only declared at a window boundary
    a_r7_rise_at_boundary: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(win_end));

    // R8: loss only after a window that saw no edge
    a_r8_fall_after_empty: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> $past(win_end && edge_cnt == '0 && !rise));

    // R8: verdict holds inside a window
    a_r8_hold_inside: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> $stable(active));
endmodule

// File: rtl/csr_regfile.sv
module csr_regfile
    import csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_phase,
    input  logic       wr_reset,
    input  logic       rd_en,
    output phase_e     phase,
    output logic       rst_pulse,
    output logic       rst_flag
);
    logic do_reset;
    assign do_reset = wr_en & wr_reset;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_0;
            rst_pulse <= 1'b0;
            rst_flag  <= 1'b0;
        end else begin
            rst_pulse <= do_reset;
            if (do_reset) begin
                phase    <= PH_0;
                rst_flag <= 1'b1;
            end else begin
                if (wr_en) phase <= phase_e'(wr_phase);
                if (rd_en) rst_flag <= 1'b0;
            end
        end
    end

    // R3: a pulse only follows a reset write
    a_r3_pulse_cause: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |-> $past(wr_en && wr_reset));

    // R3: phase is zero whenever the pulse is out
    a_r3_phase_zero: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |-> phase == PH_0);

    // R5: flag set alongside the pulse
    a_r5_flag_set: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |-> rst_flag);

    // R6: a read without a competing reset clears the flag
    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !(wr_en && wr_reset)) |=> !rst_flag);
endmodule

// File: rtl/csr_clkdet.sv
module csr_clkdet
    import csr_pkg::*;
#(
    parameter int WIN_LEN     = 256,
    parameter int EDGE_MIN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] slot_addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    input  logic       ext_clk,
    input  logic       pll_unlocked,
    output logic [1:0] phase_sel,
    output logic       ext_clk_sel,
    output logic       sw_reset_pulse
);
    logic [1:0] synced;
    logic       ext_lvl;
    logic       pll_unl_s;
    logic       ext_active;
    phase_e     phase;
    logic       rst_flag;
    csr_view_t  view;
    logic       unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[7], wr_data[4:1]};

    csr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({ext_clk, pll_unlocked}),
        .q_sync  (synced)
    );
    assign ext_lvl   = synced[1];
    assign pll_unl_s = synced[0];

    csr_clk_monitor #(.WIN_LEN(WIN_LEN), .EDGE_MIN(EDGE_MIN)) u_mon (
        .clk     (clk),
        .rst     (rst),
        .ext_lvl (ext_lvl),
        .active  (ext_active)
    );

    csr_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_phase  (wr_data[6:5]),
        .wr_reset  (wr_data[0]),
        .rd_en     (rd_en),
        .phase     (phase),
        .rst_pulse (sw_reset_pulse),
        .rst_flag  (rst_flag)
    );

    always_comb begin
        view.pll_unlock = pll_unl_s;
        view.phase      = phase;
        view.ext_active = ext_active;
        view.unit       = decode_slot(slot_addr);
        view.rst_flag   = rst_flag;
    end

    assign rd_data     = view;
    assign phase_sel   = phase;
    assign ext_clk_sel = ext_active;

    // R4: exactly one unit type reported
    a_r4_type_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(rd_data[3:1]) == 1);
endmodule

// File: tb/csr_clkdet_tb.sv
`timescale 1ns/1ps
module csr_clkdet_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] slot_addr = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       ext_clk = 1'b0;
    logic       pll_unlocked = 1'b0;
    logic [1:0] phase_sel;
    logic       ext_clk_sel;
    logic       sw_reset_pulse;

    int tests = 0;
    int fails = 0;
    logic pulse_after;

    always #4 clk = ~clk;

    csr_clkdet u_dut (
        .clk(clk), .rst(rst), .slot_addr(slot_addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .ext_clk(ext_clk), .pll_unlocked(pll_unlocked),
        .phase_sel(phase_sel), .ext_clk_sel(ext_clk_sel),
        .sw_reset_pulse(sw_reset_pulse)
    );

    // {write value, expected read value} with slot 0, no clock, PLL locked
    localparam logic [15:0] VEC [6] = '{
        16'h20_22, 16'h40_42, 16'h60_62, 16'h00_02, 16'h9E_02, 16'h7E_62
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
        pulse_after = sw_reset_pulse;
    endtask

    task automatic do_read(output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic edges(input int n, input int half);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1'b1; repeat (half) @(negedge clk);
            ext_clk = 1'b0; repeat (half) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 read", rd_data, 8'h02);
        check("R1 phase_sel", {6'd0, phase_sel}, 8'h00);
        check("R1 pulse", {7'd0, sw_reset_pulse}, 8'h00);
        check("R1 ext_sel", {7'd0, ext_clk_sel}, 8'h00);

        // R2 / R10 vector table
        for (int i = 0; i < 6; i++) begin
            do_write(VEC[i][15:8]);
            check("R10 no pulse on plain write", {7'd0, pulse_after}, 8'h00);
            do_read(v);
            check("R2 R10 read-back", v, VEC[i][7:0]);
        end
        do_write(8'h40);
        check("R2 phase_sel", {6'd0, phase_sel}, 8'h02);

        // R4 unit type
        for (int s = 0; s < 4; s++) begin
            slot_addr = 2'(s);
            #1;
            case (s)
                0, 3:    check("R4 mux type", rd_data & 8'h0E, 8'h02);
                1:       check("R4 low rx type", rd_data & 8'h0E, 8'h04);
                default: check("R4 high rx type", rd_data & 8'h0E, 8'h08);
            endcase
        end
        slot_addr = 2'd0;

        // R3 / R5 / R6 software reset and sticky flag
        do_write(8'h61);
        check("R3 pulse after write", {7'd0, pulse_after}, 8'h01);
        check("R3 phase forced 0", {6'd0, phase_sel}, 8'h00);
        @(negedge clk);
        check("R3 pulse one cycle", {7'd0, sw_reset_pulse}, 8'h00);
        do_read(v);
        check("R5 flag set", v, 8'h03);
        do_read(v);
        check("R6 flag cleared by read", v, 8'h02);

        // R6 read concurrent with reset write keeps flag
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h01; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00; rd_en = 1'b0;
        do_read(v);
        check("R6 reset wins over read", v, 8'h03);
        do_write(8'h20);
        do_read(v);
        check("R10 plain write keeps flag clear", v, 8'h22);

        // R9 PLL unlock
        pll_unlocked = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 unlock seen", rd_data & 8'h80, 8'h80);
        pll_unlocked = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 unlock gone", rd_data & 8'h80, 8'h00);

        // R8 three isolated edges never activate
        edges(3, 4);
        repeat (600) @(negedge clk);
        check("R8 three edges stay absent", rd_data & 8'h10, 8'h00);

        // R7 dense toggling activates
        edges(70, 4);
        check("R7 present bit", rd_data & 8'h10, 8'h10);
        check("R7 ext_clk_sel", {7'd0, ext_clk_sel}, 8'h01);

        // R8 sparse edges hold the verdict
        for (int i = 0; i < 8; i++) begin
            edges(1, 4);
            repeat (92) @(negedge clk);
        end
        check("R8 sparse edges hold", {7'd0, ext_clk_sel}, 8'h01);

        // R8 silence loses it
        repeat (600) @(negedge clk);
        check("R8 lost after empty window", rd_data & 8'h10, 8'h00);
        check("R8 ext_clk_sel low", {7'd0, ext_clk_sel}, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule